// File: doc/BRIEF.md
# Camera Input Sample Packer

The block sits between a camera pixel source and a 32-bit capture FIFO. It watches a 16-bit input bus qualified by a per-clock valid strobe and gathers the samples into full 32-bit words. A configuration bit picks one of two packing modes. In narrow mode every valid clock brings a single 8-bit colour component, cut from bits [9:2] of the bus, and four components fill a word. In wide mode every valid clock brings a complete YUV 4:2:2 pixel, a luma value plus one chroma value, on bits [15:0], and two pixels fill a word.

Completed words leave on a valid/ready stream. The first word of each frame carries a start-of-frame flag. A frame-start pulse realigns the packer: any partly filled word is discarded and the mode for the new frame is captured at that moment. A second configuration bit states whether the upstream gasket is set for two components per clock. The block flags a configuration error whenever that bit disagrees with the packing mode. If the consumer stalls while a finished word is still waiting, a sample that would finish the next word is dropped and a sticky overflow flag is raised.

Top module: `cam_sample_packer`

## Requirements
- R1: While reset is held and just after it, `out_valid`, `ovf_flag` and `cfg_err` are 0, and the active mode is narrow.
- R2: In narrow mode each accepted sample contributes `in_data[9:2]` as one byte. The first byte of a word lands in bits [7:0], the second in [15:8], the third in [23:16] and the fourth in [31:24]. All other bus bits are ignored.
- R3: In wide mode each accepted sample contributes all of `in_data[15:0]`. The first pixel of a word lands in bits [15:0] and the second in bits [31:16].
- R4: A word becomes visible on `out_valid`/`out_data` in the cycle after the clock edge that accepts its last sample, and not before.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` and `out_sof` stay unchanged.
- R6: A clock with `frame_start` at 1 discards any partly filled word and restarts at the first lane. A sample given in that same clock is the first sample of the new word.
- R7: The first word completed after a `frame_start` has `out_sof` at 1. Every other word has `out_sof` at 0. `out_sof` is never 1 without `out_valid`.
- R8: The mode is taken from `cfg_wide` (0 narrow, 1 wide) only in a clock with `frame_start` at 1. Changes of `cfg_wide` at other times have no effect until the next frame start.
- R9: `cfg_err` equals, one clock later, the inequality of `cfg_dbl_cmp` and `cfg_wide`.
- R10: A sample that would complete a word while `out_valid` is 1 and `out_ready` is 0 is dropped, and the partial word stays as it was. `ovf_flag` rises in the next cycle and stays 1 until reset.
- R11: Clocks with `in_valid` at 0 leave the partial word untouched, whatever `in_data` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wide | input | 1 | Packing mode: 0 narrow 8-bit components, 1 wide 16-bit pixels |
| cfg_dbl_cmp | input | 1 | Gasket double-component setting, compared with the mode |
| frame_start | input | 1 | Start-of-frame pulse; realigns and latches the mode |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Camera pixel bus |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer ready |
| out_data | output | 32 | Packed word |
| out_sof | output | 1 | Word is the first of its frame |
| ovf_flag | output | 1 | Sticky overflow indicator |
| cfg_err | output | 1 | Gasket setting disagrees with the mode |

## Verification
The bench builds the block with its default parameters: a 16-bit bus, 32-bit words, 8-bit components cut at bit offset 2 and 16-bit pixels. These give four narrow lanes and two wide lanes, so both word-completion points, the lane wrap and the byte-to-half-word ordering all come into play within a few samples. The small lane counts also let short frames reach the mid-word frame restart, the mid-frame mode change, and an overflow that drops the second pixel of a wide word while the first word is still held.

// File: rtl/cam_packer_pkg.sv
package cam_packer_pkg;

    typedef enum logic {
        PK_NARROW = 1'b0,
        PK_WIDE   = 1'b1
    } pack_mode_e;

endpackage

// File: rtl/cam_lane_merge.sv
// Writes the current sample into the lane slot(s) of the partial word.
module cam_lane_merge
    import cam_packer_pkg::*;
#(
    parameter int OUT_W      = 32,
    parameter int COMP_W     = 8,
    parameter int PIX_W      = 16,
    parameter int NARROW_LSB = 2,
    parameter int LANE_W     = 2
) (
    input  pack_mode_e         mode_i,
    input  logic [LANE_W-1:0]  lane_i,
    input  logic [PIX_W-1:0]   bus_i,
    input  logic [OUT_W-1:0]   acc_i,
    output logic [OUT_W-1:0]   acc_o,
    output logic               last_o
);
    localparam int SLOTS      = OUT_W / COMP_W;
    localparam int RATIO      = PIX_W / COMP_W;
    localparam int WIDE_LANES = SLOTS / RATIO;

    logic [COMP_W-1:0] comp;
    assign comp = bus_i[NARROW_LSB +: COMP_W];

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        localparam int WLANE = k / RATIO;
        localparam int WPART = (k % RATIO) * COMP_W;
        logic              hit;
        logic [COMP_W-1:0] val;
        always_comb begin
            if (mode_i == PK_NARROW) begin
                hit = (lane_i == LANE_W'(k));
                val = comp;
            end else begin
                hit = (lane_i == LANE_W'(WLANE));
                val = bus_i[WPART +: COMP_W];
            end
        end
        assign acc_o[k*COMP_W +: COMP_W] = hit ? val : acc_i[k*COMP_W +: COMP_W];
    end

    assign last_o = (mode_i == PK_NARROW) ? (lane_i == LANE_W'(SLOTS - 1))
                                          : (lane_i == LANE_W'(WIDE_LANES - 1));
endmodule

// File: rtl/cam_word_out.sv
// Single-entry output holding stage with valid/ready.
module cam_word_out #(
    parameter int OUT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [OUT_W-1:0] data_i,
    input  logic             sof_i,
    input  logic             ready_i,
    output logic             valid_o,
    output logic [OUT_W-1:0] data_o,
    output logic             sof_o,
    output logic             blocked_o
);
    typedef struct packed {
        logic             valid;
        logic [OUT_W-1:0] data;
        logic             sof;
    } ostate_t;

    ostate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.valid && ready_i) begin
            st_d.valid = 1'b0;
            st_d.sof   = 1'b0;
        end
        if (push_i) begin
            st_d.valid = 1'b1;
            st_d.data  = data_i;
            st_d.sof   = sof_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o   = st_q.valid;
    assign data_o    = st_q.data;
    assign sof_o     = st_q.sof;
    assign blocked_o = st_q.valid && !ready_i;
endmodule

// File: rtl/cam_sample_packer.sv
module cam_sample_packer
    import cam_packer_pkg::*;
#(
    parameter int PIX_W      = 16,
    parameter int OUT_W      = 32,
    parameter int COMP_W     = 8,
    parameter int NARROW_LSB = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wide,
    input  logic             cfg_dbl_cmp,
    input  logic             frame_start,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] out_data,
    output logic             out_sof,
    output logic             ovf_flag,
    output logic             cfg_err
);
    localparam int SLOTS  = OUT_W / COMP_W;
    localparam int LANE_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    typedef struct packed {
        pack_mode_e        mode;
        logic [LANE_W-1:0] lane;
        logic [OUT_W-1:0]  acc;
        logic              first;
        logic              ovf;
        logic              cfg_err;
    } pstate_t;

    pstate_t st_d, st_q;

    pack_mode_e        eff_mode;
    logic [LANE_W-1:0] base_lane;
    logic [OUT_W-1:0]  base_acc;
    logic              base_first;
    logic [OUT_W-1:0]  merged;
    logic              last;
    logic              blocked;
    logic              drop;
    logic              take;
    logic              push;

    // Frame start realigns and captures the mode for the new frame.
    assign eff_mode   = frame_start ? (cfg_wide ? PK_WIDE : PK_NARROW) : st_q.mode;
    assign base_lane  = frame_start ? '0 : st_q.lane;
    assign base_acc   = frame_start ? '0 : st_q.acc;
    assign base_first = frame_start ? 1'b1 : st_q.first;

    cam_lane_merge #(
        .OUT_W      (OUT_W),
        .COMP_W     (COMP_W),
        .PIX_W      (PIX_W),
        .NARROW_LSB (NARROW_LSB),
        .LANE_W     (LANE_W)
    ) u_merge (
        .mode_i (eff_mode),
        .lane_i (base_lane),
        .bus_i  (in_data),
        .acc_i  (base_acc),
        .acc_o  (merged),
        .last_o (last)
    );

    assign drop = in_valid && last && blocked;
    assign take = in_valid && !drop;
    assign push = take && last;

    always_comb begin
        st_d         = st_q;
        st_d.mode    = eff_mode;
        st_d.lane    = base_lane;
        st_d.acc     = base_acc;
        st_d.first   = base_first;
        if (take) begin
            if (last) begin
                st_d.lane  = '0;
                st_d.acc   = '0;
                st_d.first = 1'b0;
            end else begin
                st_d.lane  = base_lane + LANE_W'(1);
                st_d.acc   = merged;
            end
        end
        st_d.ovf     = st_q.ovf | drop;
        st_d.cfg_err = cfg_dbl_cmp ^ cfg_wide;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= PK_NARROW;
        end else begin
            st_q <= st_d;
        end
    end

    cam_word_out #(
        .OUT_W (OUT_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (push),
        .data_i    (merged),
        .sof_i     (base_first),
        .ready_i   (out_ready),
        .valid_o   (out_valid),
        .data_o    (out_data),
        .sof_o     (out_sof),
        .blocked_o (blocked)
    );

    assign ovf_flag = st_q.ovf;
    assign cfg_err  = st_q.cfg_err;
endmodule

// File: rtl/cam_sample_packer_chk.sv
module cam_sample_packer_chk #(
    parameter int OUT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wide,
    input logic             cfg_dbl_cmp,
    input logic             in_valid,
    input logic             out_valid,
    input logic             out_ready,
    input logic [OUT_W-1:0] out_data,
    input logic             out_sof,
    input logic             ovf_flag,
    input logic             cfg_err
);
    logic seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    a_r5_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid);

    a_r5_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> $stable(out_data) && $stable(out_sof));

    a_r7_sof_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

    a_r9_cfg_err: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> cfg_err == $past(cfg_dbl_cmp != cfg_wide));

    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    a_r10_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $rose(ovf_flag) |-> $past(in_valid && out_valid && !out_ready));
endmodule

bind cam_sample_packer cam_sample_packer_chk #(.OUT_W(OUT_W)) u_chk (.*);

// File: tb/tb_cam_sample_packer.sv
`timescale 1ns/1ps
module tb_cam_sample_packer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wide, cfg_dbl_cmp, frame_start, in_valid, out_ready;
    logic [15:0] in_data;
    logic        out_valid, out_sof, ovf_flag, cfg_err;
    logic [31:0] out_data;

    always #4 clk = ~clk;

    cam_sample_packer dut (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_dbl_cmp(cfg_dbl_cmp),
        .frame_start(frame_start), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sof(out_sof), .ovf_flag(ovf_flag), .cfg_err(cfg_err)
    );

    int          checks = 0;
    int          fails  = 0;
    bit          model_en = 1'b1;
    string       cur_tag = "R2";
    logic [32:0] exp_q[$];
    string       tag_q[$];
    bit          m_wide;
    int          m_lane;
    logic [31:0] m_acc;
    bit          m_first;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_push();
        exp_q.push_back({m_first, m_acc});
        tag_q.push_back(cur_tag);
        m_first = 1'b0;
        m_lane  = 0;
        m_acc   = '0;
    endtask

    task automatic drive(bit v, bit s, logic [15:0] d);
        @(posedge clk);
        #1;
        in_valid    = v;
        frame_start = s;
        in_data     = d;
        if (model_en) begin
            if (s) begin
                m_wide = cfg_wide; m_lane = 0; m_acc = '0; m_first = 1'b1;
            end
            if (v) begin
                if (!m_wide) begin
                    m_acc[m_lane*8 +: 8] = d[9:2];
                    if (m_lane == 3) model_push(); else m_lane++;
                end else begin
                    m_acc[m_lane*16 +: 16] = d;
                    if (m_lane == 1) model_push(); else m_lane++;
                end
            end
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 16'($urandom));
    endtask

    task automatic drain();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (exp_q.size() == 0) break;
        end
        chk({cur_tag, " drain"}, 64'(exp_q.size()), 64'd0);
    endtask

    // Scoreboard monitor: pops one expected word per handshake.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL unexpected word: actual %h expected none", {out_sof, out_data});
            end else begin
                logic [32:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({t, " word"}, 64'({out_sof, out_data}), 64'(e));
            end
        end
    end

    task automatic summary_and_end();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        summary_and_end();
    end

    initial begin
        logic [31:0] held;
        rst_n = 1'b0; cfg_wide = 1'b0; cfg_dbl_cmp = 1'b0; frame_start = 1'b0;
        in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
        m_wide = 1'b0; m_lane = 0; m_acc = '0; m_first = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 valid", 64'(out_valid), 64'd0);
        chk("R1 ovf", 64'(ovf_flag), 64'd0);
        chk("R1 cfg_err", 64'(cfg_err), 64'd0);
        @(posedge clk); #1 rst_n = 1'b1;

        // R1: narrow mode active after reset, without any frame start
        cur_tag = "R1";
        drive(1, 0, 16'h0004); drive(1, 0, 16'h0008); drive(1, 0, 16'h000c); drive(1, 0, 16'h03fc);
        idle(1); drain();

        // R2 / R11: narrow frames with gaps and noisy unused bits
        cur_tag = "R2 R11";
        drive(1, 1, 16'hf3a5); idle(2);
        drive(1, 0, 16'h0c5a); idle(1);
        drive(1, 0, 16'hfffd); drive(1, 0, 16'h1202);
        cur_tag = "R2 R7";
        for (int i = 0; i < 8; i++) begin
            drive(1, 0, 16'($urandom));
            if (i % 3 == 0) idle(1);
        end
        idle(1); drain();

        // R3: wide frame
        cur_tag = "R3";
        @(posedge clk); #1 cfg_wide = 1'b1; cfg_dbl_cmp = 1'b1;
        drive(1, 1, 16'h1234); drive(1, 0, 16'habcd);
        for (int i = 0; i < 4; i++) drive(1, 0, 16'($urandom));
        idle(1); drain();

        // R9: configuration mismatch
        @(posedge clk); #1 cfg_dbl_cmp = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R9 mismatch wide", 64'(cfg_err), 64'd1);
        @(posedge clk); #1 cfg_dbl_cmp = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R9 match wide", 64'(cfg_err), 64'd0);
        @(posedge clk); #1 cfg_wide = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R9 mismatch narrow", 64'(cfg_err), 64'd1);
        @(posedge clk); #1 cfg_dbl_cmp = 1'b0;

        // R8: mode change mid-frame takes effect only at next frame start
        cur_tag = "R8";
        drive(1, 1, 16'h0111); drive(1, 0, 16'h0222);
        #1 cfg_wide = 1'b1;
        drive(1, 0, 16'h0333); drive(1, 0, 16'h0444);
        idle(1);
        drive(1, 1, 16'h5566); drive(1, 0, 16'h7788);
        idle(1); drain();

        // R6: frame start discards a partial word (narrow and wide)
        cur_tag = "R6 R7";
        @(posedge clk); #1 cfg_wide = 1'b0;
        drive(1, 1, 16'hffff); drive(1, 0, 16'hffff); drive(1, 0, 16'hffff);
        drive(1, 1, 16'h0040); drive(1, 0, 16'h0080); drive(1, 0, 16'h00c0); drive(1, 0, 16'h0100);
        idle(1);
        @(posedge clk); #1 cfg_wide = 1'b1;
        drive(1, 1, 16'hdead);
        drive(1, 1, 16'h1111); drive(1, 0, 16'h2222);
        idle(1); drain();

        // R4 / R5: latency and hold under stall
        cur_tag = "R4";
        @(posedge clk); #1 out_ready = 1'b0; cfg_wide = 1'b0;
        drive(1, 1, 16'h0010); drive(1, 0, 16'h0020); drive(1, 0, 16'h0030); drive(1, 0, 16'h0040);
        @(negedge clk);
        chk("R4 not early", 64'(out_valid), 64'd0);
        idle(1);
        @(negedge clk);
        chk("R4 visible", 64'(out_valid), 64'd1);
        held = out_data;
        idle(3);
        @(negedge clk);
        chk("R5 valid held", 64'(out_valid), 64'd1);
        chk("R5 data held", 64'(out_data), 64'(held));
        @(posedge clk); #1 out_ready = 1'b1;
        drain();

        // R10: overflow drops the completing sample, partial word kept
        model_en = 1'b0;
        cur_tag = "R10";
        @(posedge clk); #1 out_ready = 1'b0; cfg_wide = 1'b1; cfg_dbl_cmp = 1'b1;
        drive(1, 1, 16'ha001); drive(1, 0, 16'ha002);
        drive(1, 0, 16'hb003); drive(1, 0, 16'hb004);
        idle(1);
        @(negedge clk);
        chk("R10 ovf set", 64'(ovf_flag), 64'd1);
        chk("R10 first word held", 64'({out_sof, out_data}), 64'({1'b1, 32'ha002a001}));
        exp_q.push_back({1'b1, 32'ha002a001}); tag_q.push_back("R10");
        exp_q.push_back({1'b0, 32'hc005b003}); tag_q.push_back("R10");
        @(posedge clk); #1 out_ready = 1'b1; in_valid = 1'b1; frame_start = 1'b0; in_data = 16'hc005;
        @(posedge clk); #1 in_valid = 1'b0;
        drain();
        chk("R10 ovf sticky", 64'(ovf_flag), 64'd1);
        model_en = 1'b1;

        idle(2);
        summary_and_end();
    end
endmodule